// File: doc/BRIEF.md
# Free-Running Timer with Output Compare

This block is a 16-bit up-counting timer for a small microcontroller. Software reaches it through a byte-wide internal register bus. There are five registers: a control/status byte, the two bytes of the counter, and the two bytes of a 16-bit output-compare value. The counter advances by one on every cycle where `tick` is high. When an advancing count reaches the compare value, a compare flag is raised. When the count wraps past its top, an overflow flag is raised. The interrupt request is the OR of every flag whose enable bit is set.

The counter can be written in two steps. A write to the counter's high address stores the byte in a holding latch and forces the count to 0xFFF8 (the `PRESET` parameter). A later write to the low address loads the whole count from the latch and the new byte.

Each flag is tracked by a three-state machine. In the state `FLG_IDLE` the flag is clear. In `FLG_PEND` the flag is set and has not yet been seen by a status read. In `FLG_ARMED` the flag is set and has been seen. The transitions are:

- `FLG_IDLE` to `FLG_PEND` on the flag's event (set).
- `FLG_PEND` to `FLG_ARMED` on a status read (arm).
- `FLG_ARMED` to `FLG_IDLE` on an access to the flag's data register (release).
- `FLG_PEND` or `FLG_ARMED` to `FLG_IDLE` on a control write whose flag bit is zero (mask).
- `FLG_ARMED` back to `FLG_PEND` on a fresh event (re-fire).

Top module: `frc_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the compare register reads 0xFFFF, the control/status byte reads 0x00 and `irq` is low.
- R2: The counter rises by one at each clock edge where `tick` is high and it holds when `tick` is low. It wraps from 0xFFFF to 0x0000.
- R3: A write to address 1 (counter high) stores the byte in the latch, and the counter reads 0xFFF8 from the next cycle on.
- R4: A write to address 2 (counter low) loads the counter with {latched byte, written byte}. A counter write takes priority over a `tick` in the same cycle.
- R5: The compare register sits at address 3 (bits 15:8) and address 4 (bits 7:0). Each byte is written on its own and reads back, and the other byte is unchanged. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R6: The overflow flag is bit 6 of the control/status byte. It is set from the cycle after a `tick` edge at which the counter held 0xFFFF.
- R7: The compare flag is bit 7 of the control/status byte. It is set from the cycle after a `tick` edge at which the counter equalled the compare value.
- R8: A write to the control/status byte (address 0) stores the enables: bit 0 enables overflow and bit 1 enables compare. Each flag is then ANDed with the written bit at its own position (bit 6 or bit 7).
- R9: `irq` is high exactly when some flag is set together with its enable. It follows a control write or a flag change in the next cycle.
- R10: A flag clears only when two things happen in order: a read of the control/status byte while the flag is set, and then an access to its data register. For overflow that register is address 1. For compare it is address 3 or 4. An access without the earlier status read leaves the flag set.
- R11: If a flag's event and its clearing access fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable for one clock |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from register state) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:

- Each bus access lasts one cycle, and its address and data are stable around the clock edge.
- `tick` is independent of the bus.
- Reset is held for several cycles before the first access.

The stimulus changes every input on the falling clock edge. It issues single-cycle accesses and keeps `tick` low during register sequences. The only exceptions are the deliberate collisions, which test priority and the event-versus-clear race.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int ADDR_W = 3;
    localparam int NFLAG  = 2;

    localparam logic [ADDR_W-1:0] ADR_CSR    = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CMP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CMP_LO = 3'd4;

    // flag indices; enable bit = EN_BIT0+idx, flag bit = FLAG_BIT0+idx
    localparam int FLG_OVF   = 0;
    localparam int FLG_CMP   = 1;
    localparam int EN_BIT0   = 0;
    localparam int FLAG_BIT0 = 6;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_PEND  = 2'd1,
        FLG_ARMED = 2'd2
    } flag_st_e;

endpackage

// File: rtl/frc_counter.sv
module frc_counter #(
    parameter int DATA_W = 8,
    parameter logic [2*DATA_W-1:0] PRESET = 16'hFFF8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   cnt,
    output logic                  wrap_evt
);
    localparam int CNT_W = 2 * DATA_W;

    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            hold_q <= '0;
        end else if (wr_hi) begin
            hold_q <= wdata;
            cnt    <= PRESET;
        end else if (wr_lo) begin
            cnt    <= {hold_q, wdata};
        end else if (tick) begin
            cnt    <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    assign wrap_evt = tick && !wr_hi && !wr_lo && (cnt == {CNT_W{1'b1}});

    p_preset_r3: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (cnt == PRESET));
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> (cnt[DATA_W-1:0] == $past(wdata)));
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_hi && !wr_lo) |=> (cnt == $past(cnt) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_hi && !wr_lo) |=> $stable(cnt));

endmodule

// File: rtl/frc_compare.sv
module frc_compare #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [2*DATA_W-1:0]   cnt,
    output logic [2*DATA_W-1:0]   cmp,
    output logic                  match_evt
);
    localparam int CNT_W = 2 * DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= {CNT_W{1'b1}};
        end else begin
            if (wr_hi) cmp[CNT_W-1:DATA_W] <= wdata;
            if (wr_lo) cmp[DATA_W-1:0]     <= wdata;
        end
    end

    assign match_evt = tick && (cnt == cmp);

    p_cmp_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_hi && !wr_lo) |=> $stable(cmp));
    p_cmp_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> (cmp[CNT_W-1:DATA_W] == $past(wdata)) &&
                              (cmp[DATA_W-1:0] == $past(cmp[DATA_W-1:0])));

endmodule

// File: rtl/frc_flag.sv
module frc_flag
    import frc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic csr_wr,
    input  logic keep,
    input  logic stat_rd,
    input  logic data_acc,
    output logic flag
);
    flag_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= FLG_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE: begin
                if (evt) st_d = FLG_PEND;
            end
            FLG_PEND: begin
                if (evt)                  st_d = FLG_PEND;
                else if (csr_wr && !keep) st_d = FLG_IDLE;
                else if (stat_rd)         st_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (evt)                  st_d = FLG_PEND;
                else if (csr_wr && !keep) st_d = FLG_IDLE;
                else if (data_acc)        st_d = FLG_IDLE;
            end
            default: st_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (st_q != FLG_IDLE);
    end

    p_evt_wins_r11: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag);
    p_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && !keep && !evt) |=> !flag);
    p_no_early_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == FLG_PEND && !(csr_wr && !keep)) |=> flag);
    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == FLG_ARMED && data_acc && !evt) |=> !flag);

endmodule

// File: rtl/frc_timer.sv
module frc_timer
    import frc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [2*DATA_W-1:0] PRESET = 16'hFFF8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic              wr_en, rd_en;
    logic              csr_wr, csr_rd;
    logic [CNT_W-1:0]  cnt, cmp;
    logic              wrap_evt, match_evt;
    logic [NFLAG-1:0]  en_q, flag_v, evt_v, acc_v;
    logic [7:0]        csr_val;

    assign wr_en  = bus_sel && bus_wr;
    assign rd_en  = bus_sel && !bus_wr;
    assign csr_wr = wr_en && (bus_addr == ADR_CSR);
    assign csr_rd = rd_en && (bus_addr == ADR_CSR);

    frc_counter #(.DATA_W(DATA_W), .PRESET(PRESET)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_hi    (wr_en && (bus_addr == ADR_CNT_HI)),
        .wr_lo    (wr_en && (bus_addr == ADR_CNT_LO)),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .wrap_evt (wrap_evt)
    );

    frc_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wr_hi     (wr_en && (bus_addr == ADR_CMP_HI)),
        .wr_lo     (wr_en && (bus_addr == ADR_CMP_LO)),
        .wdata     (bus_wdata),
        .cnt       (cnt),
        .cmp       (cmp),
        .match_evt (match_evt)
    );

    always_comb begin
        evt_v          = '0;
        acc_v          = '0;
        evt_v[FLG_OVF] = wrap_evt;
        evt_v[FLG_CMP] = match_evt;
        acc_v[FLG_OVF] = bus_sel && (bus_addr == ADR_CNT_HI);
        acc_v[FLG_CMP] = bus_sel && ((bus_addr == ADR_CMP_HI) || (bus_addr == ADR_CMP_LO));
    end

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        frc_flag u_flag (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_v[gi]),
            .csr_wr   (csr_wr),
            .keep     (bus_wdata[FLAG_BIT0+gi]),
            .stat_rd  (csr_rd),
            .data_acc (acc_v[gi]),
            .flag     (flag_v[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (csr_wr) en_q <= bus_wdata[EN_BIT0 +: NFLAG];
    end

    always_comb begin
        csr_val = '0;
        for (int i = 0; i < NFLAG; i++) begin
            csr_val[FLAG_BIT0+i] = flag_v[i];
            csr_val[EN_BIT0+i]   = en_q[i];
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_CSR:    bus_rdata = csr_val;
            ADR_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
            ADR_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
            ADR_CMP_HI: bus_rdata = cmp[CNT_W-1:DATA_W];
            ADR_CMP_LO: bus_rdata = cmp[DATA_W-1:0];
            default:    bus_rdata = 8'h00;
        endcase
    end

    assign irq = |(flag_v & en_q);

    p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|flag_v));
    p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && (bus_wdata[EN_BIT0 +: NFLAG] == '0)) |=> !irq);
    p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> (flag_v[FLG_OVF] && cnt == '0));

endmodule

// File: tb/sim_frc_timer.sv
module sim_frc_timer;
    import frc_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frc_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 0;
    endtask

    task automatic expect_rd(input string tag, input logic [2:0] a, input logic [7:0] e);
        logic [7:0] v;
        brd(a, v);
        chk(tag, v, e);
    endtask

    task automatic run(input int n);
        @(negedge clk); tick = 1;
        repeat (n) @(posedge clk);
        @(negedge clk); tick = 0;
    endtask

    task automatic load_cnt(input logic [15:0] v);
        bwr(ADR_CNT_HI, v[15:8]);
        bwr(ADR_CNT_LO, v[7:0]);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(64'd8 * 64'd200000);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        logic [15:0] start, cmpv;
        logic [16:0] sum;
        logic [7:0]  v;
        int          n;
        bit          e_ovf, e_cmp;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        #1 chk("R1 irq", irq, 0);
        expect_rd("R1 csr", ADR_CSR, 8'h00);
        expect_rd("R1 cnt_hi", ADR_CNT_HI, 8'h00);
        expect_rd("R1 cnt_lo", ADR_CNT_LO, 8'h00);
        expect_rd("R1 cmp_hi", ADR_CMP_HI, 8'hFF);
        expect_rd("R1 cmp_lo", ADR_CMP_LO, 8'hFF);

        // R5 unused addresses
        for (int a = 5; a < 8; a++) begin
            bwr(a[2:0], 8'hA5);
            expect_rd("R5 unused reads zero", a[2:0], 8'h00);
        end
        expect_rd("R5 unused write no effect cmp", ADR_CMP_HI, 8'hFF);
        expect_rd("R5 unused write no effect csr", ADR_CSR, 8'h00);
        expect_rd("R5 unused write no effect cnt", ADR_CNT_LO, 8'h00);

        // R3 / R4 sweep over every high byte
        for (int h = 0; h < 256; h++) begin
            bwr(ADR_CNT_HI, h[7:0]);
            expect_rd("R3 preset hi", ADR_CNT_HI, 8'hFF);
            expect_rd("R3 preset lo", ADR_CNT_LO, 8'hF8);
            bwr(ADR_CNT_LO, h[7:0] ^ 8'h5A);
            expect_rd("R4 load hi", ADR_CNT_HI, h[7:0]);
            expect_rd("R4 load lo", ADR_CNT_LO, h[7:0] ^ 8'h5A);
        end

        // R4 counter write beats tick
        bwr(ADR_CNT_HI, 8'h40);
        @(negedge clk); tick = 1; sel = 1; wr = 1; addr = ADR_CNT_LO; wdata = 8'h20;
        @(negedge clk); tick = 0; sel = 0; wr = 0;
        expect_rd("R4 write beats tick", ADR_CNT_LO, 8'h20);

        // R2 hold with tick low
        repeat (5) @(negedge clk);
        expect_rd("R2 hold", ADR_CNT_LO, 8'h20);

        // R5 independent compare bytes
        for (int k = 0; k < 16; k++) begin
            bwr(ADR_CMP_HI, 8'(k * 17));
            expect_rd("R5 cmp hi", ADR_CMP_HI, 8'(k * 17));
            expect_rd("R5 cmp lo untouched", ADR_CMP_LO, 8'(8'hFF - k));
            bwr(ADR_CMP_LO, 8'(8'hFE - k));
            expect_rd("R5 cmp lo", ADR_CMP_LO, 8'(8'hFE - k));
            expect_rd("R5 cmp hi untouched", ADR_CMP_HI, 8'(k * 17));
        end

        // R2 R6 R7 R9 sweep
        for (int i = 0; i < 256; i++) begin
            start = (i % 3 == 0) ? 16'(16'hFFFF - (i % 11)) : 16'(i * 16'h0517);
            n     = 1 + (i % 13);
            cmpv  = 16'(start + 16'(i % 17));
            bwr(ADR_CSR, 8'h03);
            bwr(ADR_CMP_HI, cmpv[15:8]);
            bwr(ADR_CMP_LO, cmpv[7:0]);
            load_cnt(start);
            run(n);
            sum   = {1'b0, start} + 17'(n);
            e_ovf = sum[16];
            e_cmp = (16'(cmpv - start) < 16'(n));
            #1 chk("R9 irq", irq, int'(e_ovf | e_cmp));
            expect_rd("R6 R7 flags", ADR_CSR, {e_cmp, e_ovf, 6'b000011});
            expect_rd("R2 count hi", ADR_CNT_HI, sum[15:8]);
            expect_rd("R2 count lo", ADR_CNT_LO, sum[7:0]);
        end

        // R10 overflow clear sequence
        bwr(ADR_CSR, 8'h01);
        load_cnt(16'hFFFF);
        run(1);
        #1 chk("R6 R9 ovf irq", irq, 1);
        expect_rd("R10 unarmed access", ADR_CNT_HI, 8'h00);
        expect_rd("R10 flag survives", ADR_CSR, 8'h41);
        expect_rd("R10 unrelated access", ADR_CNT_LO, 8'h00);
        expect_rd("R10 still set", ADR_CSR, 8'h41);
        expect_rd("R10 release", ADR_CNT_HI, 8'h00);
        expect_rd("R10 ovf cleared", ADR_CSR, 8'h01);
        #1 chk("R9 irq low", irq, 0);

        // R10 compare clear, R9 enable gating
        bwr(ADR_CMP_HI, 8'h00);
        bwr(ADR_CMP_LO, 8'h05);
        run(6);
        #1 chk("R9 flag without enable", irq, 0);
        expect_rd("R7 cmp flag", ADR_CSR, 8'h81);
        bwr(ADR_CSR, 8'h83);
        #1 chk("R9 enable raises irq", irq, 1);
        expect_rd("R8 keep cmp", ADR_CSR, 8'h83);
        bwr(ADR_CMP_LO, 8'h05);
        expect_rd("R10 cmp cleared", ADR_CSR, 8'h03);

        // R8 AND with written value
        bwr(ADR_CMP_HI, 8'hFF);
        bwr(ADR_CMP_LO, 8'hFF);
        load_cnt(16'hFFFF);
        run(1);
        #1 chk("R8 both set irq", irq, 1);
        bwr(ADR_CSR, 8'h83);
        expect_rd("R8 ovf dropped cmp kept", ADR_CSR, 8'h83);
        bwr(ADR_CSR, 8'h03);
        expect_rd("R8 cmp dropped", ADR_CSR, 8'h03);
        #1 chk("R8 irq after mask", irq, 0);

        // R11 event and release in same cycle
        bwr(ADR_CMP_HI, 8'h00);
        bwr(ADR_CMP_LO, 8'h10);
        load_cnt(16'h0010);
        run(1);
        load_cnt(16'h0010);
        expect_rd("R11 setup", ADR_CSR, 8'h83);
        @(negedge clk); tick = 1; sel = 1; wr = 1; addr = ADR_CMP_LO; wdata = 8'h10;
        @(negedge clk); tick = 0; sel = 0; wr = 0;
        expect_rd("R11 flag kept", ADR_CSR, 8'h83);
        brd(ADR_CNT_LO, v);
        chk("R11 counter advanced", v, 8'h11);

        finish_up();
    end

endmodule